// File: doc/BRIEF.md
# Multi-Class Reset Register Bank

This block is the register file at the front of a flash controller. A host reaches it through a synchronous port that carries a 16-bit word address and 16-bit data. Read data is combinational from the address. Writes take effect on the rising clock edge. The sequencing logic behind the block uses a separate load port to deposit ECC results, controller status and write-protect status. These are read-only to the host.

There are four kinds of reset, and each register follows its own rule for each kind. A cold reset comes from a low `por_n`. A warm reset comes from a low `warm_n` pin. A hot reset is raised by writing `16'h00F3` to the command register, or by writing `16'h00F0` while `boot_sel` is high. Writing `16'h00F0` while `boot_sel` is low is only a flash-core reset, and it resets nothing in this bank. Every command write, whatever its value, also clears the ECC registers.

All reset sources are sampled on the clock edge. When several arrive in the same cycle, the broadest one wins.

Top module: `mcrb_regs`

## Requirements
- R1: The identification words are constant and are not changed by any reset or write: F000h=00ECh, F003h=0800h, F004h=0200h, F005h=0201h, F006h=0000h.
- R2: After a cold reset (`por_n` low at an edge):
  - F100h–F104h, F107h, F200h, F220h, F240h, F24Ch and FF00h–FF08h read 0000h.
  - F221h reads 40C0h.
  - F241h reads 8080h.
  - F24Eh reads 0002h.
- R3: A warm reset (`warm_n` low at an edge) gives the same values as R2, except that the two OTP lock bits of F240h (bits 6 and 5) keep their values.
- R4: A hot reset is raised by a write of 00F3h to F220h, or a write of 00F0h to F220h with `boot_sel`=1. After it:
  - F100h–F104h, F107h, F200h, F220h and FF00h–FF08h read 0000h.
  - F240h keeps only bits 6 and 5.
  - F241h reads 8010h.
- R5: On a hot reset, bits 15, 14, 7 and 6 of F221h keep their values and every other bit takes its 40C0h default.
- R6: A hot reset leaves F24Ch and F24Eh unchanged.
- R7: A write of 00F0h to F220h with `boot_sel`=0 is stored as the command and leaves every register other than the ECC registers unchanged.
- R8: Any write to F220h clears FF00h–FF08h at that edge. The clear takes priority over a load to those registers in the same cycle.
- R9: Cold beats warm, and warm beats hot. A cold or warm reset discards a host write made in the same cycle, and a cold or warm reset on F240h/F24Eh beats a same-cycle load.
- R10: Unmapped addresses (for example F001h, F105h, F24Dh, FF09h) read 0000h. Host writes to F000h–F006h, F240h, F24Eh and FF00h–FF08h are ignored.
- R11: A load with `ld_en`=1 writes `ld_val` at the edge to the register chosen by `ld_sel`: 0–8 select FF00h–FF08h, 9 selects F240h, 10 selects F24Eh.
- R12: Host-writable registers (F100h–F104h, F107h, F200h, F220h, F221h, F241h, F24Ch) read back the last value written, in the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Cold (power-on) reset, active low, sampled on the edge |
| warm_n | input | 1 | Warm reset pin, active low, sampled on the edge |
| boot_sel | input | 1 | Boot-partition flag; turns a 00F0h command into a hot reset |
| we | input | 1 | Host write strobe |
| addr | input | 16 | Host word address (read and write) |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Combinational read data for `addr` |
| ld_en | input | 1 | Internal load strobe |
| ld_sel | input | SW (4) | Internal load target: 0–8 ECC, 9 controller status, 10 write-protect |
| ld_val | input | 16 | Internal load value |

## Verification
Two events often fall in the same clock cycle: a command write, which clears the ECC words or raises a hot reset, and a reset or internal load hitting the same registers. The bench drives a command write together with an ECC load in one cycle and expects the ECC words at zero. It raises cold, warm and a hot-reset command together, and then warm with a hot-reset command. After each case it reads back every address and compares it with a table built from the broadest class. Randomised writes, loads and command values, including the reset codes under both settings of `boot_sel`, are checked the same way.

// File: rtl/mcrb_regs.sv
`timescale 1ns/1ps
module mcrb_regs #(
  parameter int          ECC_SECT = 4,
  parameter logic [15:0] CFG_DEF  = 16'h40C0,
  parameter logic [15:0] CFG_KEEP = 16'hC0C0,
  parameter logic [15:0] OTP_MASK = 16'h0060,
  localparam int         NECC     = 2*ECC_SECT+1,
  localparam int         SW       = $clog2(NECC+2)
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          warm_n,
  input  logic          boot_sel,
  input  logic          we,
  input  logic [15:0]   addr,
  input  logic [15:0]   wdata,
  output logic [15:0]   rdata,
  input  logic          ld_en,
  input  logic [SW-1:0] ld_sel,
  input  logic [15:0]   ld_val
);
  localparam logic [SW-1:0] SEL_CTL = SW'(NECC);
  localparam logic [SW-1:0] SEL_WP  = SW'(NECC+1);
  localparam logic [7:0]    ECC_LIM = 8'(NECC);

  logic [15:0] sa [8];
  logic [15:0] sbuf, cmd, cfg, intr, sblk, wp, ctl;
  logic [15:0] ecc [NECC];

  wire cold   = !por_n;
  wire warm   = !warm_n && !cold;
  wire cw     = cold || warm;
  wire cmd_wr = we && addr == 16'hF220;
  wire hot    = cmd_wr && !cw &&
                (wdata == 16'h00F3 || (wdata == 16'h00F0 && boot_sel));
  wire any_rst = cw || hot;
  wire wr_ok   = we && !cw;
  wire sa_hit  = addr[15:3] == 13'h1E20 && (addr[2:0] <= 3'd4 || addr[2:0] == 3'd7);
  wire ecc_hit = addr[15:8] == 8'hFF && addr[7:0] < ECC_LIM;

  always_ff @(posedge clk) begin
    if (any_rst) begin
      for (int i = 0; i < 8; i++) sa[i] <= '0;
      sbuf <= '0;
      cmd  <= '0;
    end else if (wr_ok) begin
      if (sa_hit) sa[addr[2:0]] <= wdata;
      if (addr == 16'hF200) sbuf <= wdata;
      if (cmd_wr) cmd <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (cw) begin
      cfg  <= CFG_DEF;
      intr <= 16'h8080;
      sblk <= '0;
    end else if (hot) begin
      cfg  <= (cfg & CFG_KEEP) | (CFG_DEF & ~CFG_KEEP);
      intr <= 16'h8010;
    end else if (wr_ok) begin
      case (addr)
        16'hF221: cfg  <= wdata;
        16'hF241: intr <= wdata;
        16'hF24C: sblk <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (cold) begin
      ctl <= '0;
      wp  <= 16'h0002;
    end else if (warm) begin
      ctl <= ctl & OTP_MASK;
      wp  <= 16'h0002;
    end else begin
      if (hot) ctl <= ctl & OTP_MASK;
      else if (ld_en && ld_sel == SEL_CTL) ctl <= ld_val;
      if (ld_en && ld_sel == SEL_WP) wp <= ld_val;
    end
  end

  always_ff @(posedge clk) begin
    if (any_rst || cmd_wr) begin
      for (int i = 0; i < NECC; i++) ecc[i] <= '0;
    end else if (ld_en && ld_sel < SEL_CTL) begin
      ecc[ld_sel] <= ld_val;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      16'hF000: rdata = 16'h00EC;
      16'hF003: rdata = 16'h0800;
      16'hF004: rdata = 16'h0200;
      16'hF005: rdata = 16'h0201;
      16'hF006: rdata = 16'h0000;
      16'hF200: rdata = sbuf;
      16'hF220: rdata = cmd;
      16'hF221: rdata = cfg;
      16'hF240: rdata = ctl;
      16'hF241: rdata = intr;
      16'hF24C: rdata = sblk;
      16'hF24E: rdata = wp;
      default: ;
    endcase
    if (sa_hit)  rdata = sa[addr[2:0]];
    if (ecc_hit) rdata = ecc[addr[SW-1:0]];
  end
endmodule

module mcrb_regs_chk (
  input logic        clk,
  input logic        por_n,
  input logic        warm_n,
  input logic        boot_sel,
  input logic        we,
  input logic [15:0] addr,
  input logic [15:0] wdata,
  input logic [15:0] rdata
);
  wire hot_req = por_n && warm_n && we && addr == 16'hF220 &&
                 (wdata == 16'h00F3 || (wdata == 16'h00F0 && boot_sel));

  // R1
  id_const_chk: assert property (@(posedge clk) disable iff (!por_n)
    addr == 16'hF000 |-> rdata == 16'h00EC);

  // R3
  warm_int_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!$past(warm_n) && addr == 16'hF241) |-> rdata == 16'h8080);

  // R4
  hot_int_chk: assert property (@(posedge clk) disable iff (!por_n)
    ($past(hot_req) && addr == 16'hF241) |-> rdata == 16'h8010);

  // R5
  hot_cfg_chk: assert property (@(posedge clk) disable iff (!por_n)
    ($past(hot_req) && addr == 16'hF221) |-> (rdata & 16'h3F3F) == 16'h0000);

  // R8
  ecc_clr_chk: assert property (@(posedge clk) disable iff (!por_n)
    ($past(we && addr == 16'hF220) && addr == 16'hFF00) |-> rdata == 16'h0000);

  // R10
  unmapped_chk: assert property (@(posedge clk) disable iff (!por_n)
    addr == 16'hF24D |-> rdata == 16'h0000);
endmodule

bind mcrb_regs mcrb_regs_chk u_chk (.*);

// File: tb/test_mcrb_regs.sv
`timescale 1ns/1ps
module test_mcrb_regs;
  logic clk = 0, por_n = 0, warm_n = 1, boot_sel = 0, we = 0, ld_en = 0;
  logic [15:0] addr = 16'hF000, wdata = 0, ld_val = 0, rdata;
  logic [3:0] ld_sel = 0;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  mcrb_regs i_mcrb_regs (.clk, .por_n, .warm_n, .boot_sel, .we, .addr, .wdata,
                         .rdata, .ld_en, .ld_sel, .ld_val);

  localparam logic [15:0] ALIST [33] = '{
    16'hF000, 16'hF001, 16'hF002, 16'hF003, 16'hF004, 16'hF005, 16'hF006,
    16'hF100, 16'hF101, 16'hF102, 16'hF103, 16'hF104, 16'hF105, 16'hF106, 16'hF107,
    16'hF200, 16'hF220, 16'hF221, 16'hF240, 16'hF241, 16'hF24C, 16'hF24D, 16'hF24E,
    16'hFF00, 16'hFF01, 16'hFF02, 16'hFF03, 16'hFF04, 16'hFF05, 16'hFF06, 16'hFF07,
    16'hFF08, 16'hFF09};

  logic [15:0] m_sa [8];
  logic [15:0] m_ecc [9];
  logic [15:0] m_sbuf, m_cmd, m_cfg, m_int, m_blk, m_wp, m_st;

  function automatic bit is_sa(input logic [15:0] a);
    return a[15:3] == 13'h1E20 && (a[2:0] <= 3'd4 || a[2:0] == 3'd7);
  endfunction

  function automatic logic [15:0] mread(input logic [15:0] a);
    if (is_sa(a)) return m_sa[a[2:0]];
    if (a >= 16'hFF00 && a <= 16'hFF08) return m_ecc[int'(a[3:0])];
    case (a)
      16'hF000: return 16'h00EC;
      16'hF003: return 16'h0800;
      16'hF004: return 16'h0200;
      16'hF005: return 16'h0201;
      16'hF200: return m_sbuf;
      16'hF220: return m_cmd;
      16'hF221: return m_cfg;
      16'hF240: return m_st;
      16'hF241: return m_int;
      16'hF24C: return m_blk;
      16'hF24E: return m_wp;
      default:  return 16'h0000;
    endcase
  endfunction

  task automatic m_clear_common();
    for (int i = 0; i < 8; i++) m_sa[i] = 0;
    for (int i = 0; i < 9; i++) m_ecc[i] = 0;
    m_sbuf = 0; m_cmd = 0;
  endtask

  task automatic m_cold();
    m_clear_common();
    m_cfg = 16'h40C0; m_int = 16'h8080; m_blk = 0; m_wp = 16'h0002; m_st = 0;
  endtask

  task automatic m_warm();
    logic [15:0] keep;
    keep = m_st & 16'h0060;
    m_cold();
    m_st = keep;
  endtask

  task automatic m_hot();
    m_clear_common();
    m_cfg = m_cfg & 16'hC0C0;
    m_int = 16'h8010;
    m_st  = m_st & 16'h0060;
  endtask

  task automatic m_write(input logic [15:0] a, input logic [15:0] d);
    if (a == 16'hF220) begin
      for (int i = 0; i < 9; i++) m_ecc[i] = 0;
      if (d == 16'h00F3 || (d == 16'h00F0 && boot_sel)) m_hot();
      else m_cmd = d;
    end else if (is_sa(a)) m_sa[a[2:0]] = d;
    else case (a)
      16'hF200: m_sbuf = d;
      16'hF221: m_cfg = d;
      16'hF241: m_int = d;
      16'hF24C: m_blk = d;
      default: ;
    endcase
  endtask

  task automatic m_load(input int sel, input logic [15:0] v);
    if (sel < 9) m_ecc[sel] = v;
    else if (sel == 9) m_st = v;
    else if (sel == 10) m_wp = v;
  endtask

  task automatic bwr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(posedge clk); #1 we = 0;
    m_write(a, d);
  endtask

  task automatic bld(input int sel, input logic [15:0] v);
    @(negedge clk); ld_en = 1; ld_sel = 4'(sel); ld_val = v;
    @(posedge clk); #1 ld_en = 0;
    m_load(sel, v);
  endtask

  task automatic chk(input string r, input logic [15:0] a, input logic [15:0] got,
                     input logic [15:0] expv);
    checks++;
    if (got !== expv) begin
      errors++;
      $display("FAIL %s addr=%h got=%h expected=%h", r, a, got, expv);
    end
  endtask

  task automatic rd_chk(input string r, input logic [15:0] a);
    @(negedge clk); addr = a; #1;
    chk(r, a, rdata, mread(a));
  endtask

  task automatic chk_all(input string r);
    foreach (ALIST[i]) rd_chk(r, ALIST[i]);
  endtask

  task automatic fill();
    logic [15:0] d;
    d = 16'($urandom);
    if (d == 16'h00F3 || d == 16'h00F0) d = 16'h1234;
    bwr(16'hF220, d);
    for (int i = 0; i < 8; i++) if (i <= 4 || i == 7) bwr(16'hF100 + 16'(i), 16'($urandom));
    bwr(16'hF200, 16'($urandom));
    bwr(16'hF221, 16'($urandom) | 16'hC0C0);
    bwr(16'hF241, 16'($urandom));
    bwr(16'hF24C, 16'($urandom) | 16'h0100);
    for (int i = 0; i < 9; i++) bld(i, 16'($urandom) | 16'h0001);
    bld(9, 16'($urandom) | 16'h0060);
    bld(10, 16'($urandom) | 16'h8000);
    bwr(16'hF000, 16'hFFFF);
    bwr(16'hF240, 16'h0000);
    bwr(16'hF24E, 16'h5555);
    bwr(16'hFF00, 16'h0000);
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20251));
    repeat (3) @(posedge clk);
    @(negedge clk); por_n = 1;
    m_cold();
    chk_all("R2");

    fill(); chk_all("R10 R11 R12");
    @(negedge clk); warm_n = 0; @(posedge clk); #1 warm_n = 1;
    m_warm(); chk_all("R3");

    fill();
    bwr(16'hF220, 16'h00F3);
    chk_all("R4 R5 R6");

    fill(); boot_sel = 1;
    bwr(16'hF220, 16'h00F0);
    chk_all("R4 boot");

    fill(); boot_sel = 0;
    bwr(16'hF220, 16'h00F0);
    chk_all("R7");

    fill();
    bwr(16'hF220, 16'h0011);
    chk_all("R8 plain command");

    fill();
    @(negedge clk); we = 1; addr = 16'hF220; wdata = 16'h0022;
    ld_en = 1; ld_sel = 4'd3; ld_val = 16'hBEEF;
    @(posedge clk); #1 we = 0; ld_en = 0;
    m_write(16'hF220, 16'h0022);
    chk_all("R8 same-cycle load");

    fill();
    @(negedge clk); por_n = 0; warm_n = 0; we = 1; addr = 16'hF220; wdata = 16'h00F3;
    @(posedge clk); #1 por_n = 1; warm_n = 1; we = 0;
    m_cold(); chk_all("R9 cold wins");

    fill();
    @(negedge clk); warm_n = 0; we = 1; addr = 16'hF220; wdata = 16'h00F3;
    @(posedge clk); #1 warm_n = 1; we = 0;
    m_warm(); chk_all("R9 warm over hot");

    fill();
    @(negedge clk); warm_n = 0; we = 1; addr = 16'hF101; wdata = 16'hAAAA;
    ld_en = 1; ld_sel = 4'd10; ld_val = 16'h7777;
    @(posedge clk); #1 warm_n = 1; we = 0; ld_en = 0;
    m_warm(); chk_all("R9 warm over write");

    fill();
    @(negedge clk); por_n = 0; @(posedge clk); #1 por_n = 1;
    m_cold(); chk_all("R2 after fill");

    for (int it = 0; it < 600; it++) begin
      int op;
      op = $urandom_range(0, 5);
      if ($urandom_range(0, 15) == 0) boot_sel = ~boot_sel;
      if (op == 0) begin
        logic [15:0] d;
        d = 16'($urandom);
        case ($urandom_range(0, 7))
          0: d = 16'h00F3;
          1: d = 16'h00F0;
          default: ;
        endcase
        bwr(16'hF220, d);
      end else if (op == 1) bwr(ALIST[$urandom_range(0, 32)], 16'($urandom));
      else if (op == 2) bld($urandom_range(0, 10), 16'($urandom));
      else rd_chk("R12 random", ALIST[$urandom_range(0, 32)]);
    end
    chk_all("R1 R12 final");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule